// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Core

This block is a true dual-port memory with two fully independent access ports, called left and right. Each port has its own clock and reset. On every rising edge a port captures its address, write data, read/write control and a pair of chip enables of opposite polarity. Either port can read or write any word at any time.

Each port also has an output-enable input that acts without a clock. A static mode input on each port chooses between two read latencies. In flow-through mode the word appears right after the capturing edge. In pipelined mode it appears one edge later.

The read path does not drive a tri-state pad. It is modelled as a data bus plus a drive-enable flag, and the bus reads zero whenever the flag is low. The default size is kept small for simulation. Setting the address-width parameter to 17 gives the full 128K-word array.

Top module: `dpr_core`

## Requirements
- R1: A port is selected only when its `ce_n` is 0 and its `ce` is 1 at the rising edge. An unselected edge writes nothing, and in flow-through mode `dvalid` is 0 after that edge.
- R2: A selected edge with `wr_n` = 0 stores `din` at `addr`. A later read of that address from either port returns it.
- R3: A selected edge with `wr_n` = 1 is a read of `addr`. While `oe_n` is 0, the port presents that word on `dout` with `dvalid` = 1.
- R4: While `oe_n` is 1, `dvalid` is 0 and `dout` is all zeros, with no clock edge needed. When `oe_n` returns to 0, a pending read shows again within the same cycle.
- R5: Flow-through (`pipe` = 0): a read captured at edge k is presented from edge k until edge k+1.
- R6: Pipelined (`pipe` = 1): a read captured at edge k is presented from edge k+1 until edge k+2. Between edges k and k+1 it is not shown.
- R7: Each port's `pipe` input governs only that port, so one port can run flow-through while the other runs pipelined.
- R8: When both ports write the same address on the same edge (common clock), the left port's data is stored. Writes to different addresses on the same edge both land.
- R9: When one port reads an address on the same edge that the other port writes it, the read returns the data held before that edge.
- R10: During and after reset, `dvalid` is 0 and `dout` is 0 on both ports until a read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_ce | input | 1 | Left chip enable, active high |
| l_wr_n | input | 1 | Left read/write: 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low, asynchronous |
| l_pipe | input | 1 | Left mode: 0 flow-through, 1 pipelined |
| l_addr | input | AW | Left address |
| l_din | input | DW | Left write data |
| l_dout | output | DW | Left read data, zero when not driven |
| l_dvalid | output | 1 | Left drive-enable flag |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port reset, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_ce | input | 1 | Right chip enable, active high |
| r_wr_n | input | 1 | Right read/write: 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low, asynchronous |
| r_pipe | input | 1 | Right mode: 0 flow-through, 1 pipelined |
| r_addr | input | AW | Right address |
| r_din | input | DW | Right write data |
| r_dout | output | DW | Right read data, zero when not driven |
| r_dvalid | output | 1 | Right drive-enable flag |

## Verification
The array is stored as two banks whose bitwise XOR forms each word. A corrupted bank therefore shows up as a wrong word on the very next read of that address, from either port. A fault in the collision guard leaves a mixed word after a same-address double write, and the next read exposes it. A wrong stage register or mode selection moves `dvalid` by one edge, and the bench catches this because it samples each read at exactly one half-cycle after the edge where the word should appear.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   typedef enum logic {
      MODE_FLOW = 1'b0,
      MODE_PIPE = 1'b1
   } rd_mode_e;

   function automatic logic port_selected(input logic ce_n, input logic ce);
      return (!ce_n) && ce;
   endfunction

endpackage

// File: rtl/dpr_bank.sv
// One storage bank: written from a single clock domain, read combinationally
// at both ports' addresses.
module dpr_bank #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [AW-1:0] ra_l,
   input  logic [AW-1:0] ra_r,
   output logic [DW-1:0] rd_l,
   output logic [DW-1:0] rd_r
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   assign rd_l = mem[ra_l];
   assign rd_r = mem[ra_r];
endmodule

// File: rtl/dpr_port.sv
// One access port: select decode, write encoding, read stages, output gating.
module dpr_port
   import dpr_pkg::*;
#(
   parameter int AW       = 10,
   parameter int DW       = 8,
   parameter bit HAS_PIPE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          ce,
   input  logic          wr_n,
   input  logic          oe_n,
   input  logic          pipe,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic [DW-1:0] word_now,
   input  logic [DW-1:0] peer_word,
   input  logic          wr_block,
   output logic          wr_req,
   output logic          bank_we,
   output logic [DW-1:0] bank_wd,
   output logic [DW-1:0] dout,
   output logic          dvalid
);
   localparam int NSTG = HAS_PIPE ? 2 : 1;

   logic          sel_in;
   logic          rd_req;
   logic          stg_v [NSTG];
   logic [DW-1:0] stg_d [NSTG];
   logic          pick_v;
   logic [DW-1:0] pick_d;
   logic [1:0]    age;

   assign sel_in  = port_selected(ce_n, ce);
   assign wr_req  = sel_in && !wr_n;
   assign rd_req  = sel_in && wr_n;
   assign bank_we = wr_req && !wr_block;
   assign bank_wd = din ^ peer_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v[0] <= 1'b0;
         stg_d[0] <= '0;
      end else begin
         stg_v[0] <= rd_req;
         stg_d[0] <= word_now;
      end
   end

   generate
      if (HAS_PIPE) begin : g_pipe
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_v[1] <= 1'b0;
               stg_d[1] <= '0;
            end else begin
               stg_v[1] <= stg_v[0];
               stg_d[1] <= stg_d[0];
            end
         end
         always_comb begin
            if (rd_mode_e'(pipe) == MODE_PIPE) begin
               pick_v = stg_v[1];
               pick_d = stg_d[1];
            end else begin
               pick_v = stg_v[0];
               pick_d = stg_d[0];
            end
         end
      end else begin : g_flow_only
         assign pick_v = stg_v[0];
         assign pick_d = stg_d[0];
      end
   endgenerate

   assign dvalid = pick_v && !oe_n;
   assign dout   = dvalid ? pick_d : '0;

   // edges since reset, saturating; used only to bound look-back
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && (!pipe || !HAS_PIPE) && !$past(sel_in)) |-> !dvalid);

   a_r4_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!dvalid && dout == '0));

   a_r5_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && (!pipe || !HAS_PIPE) && !oe_n) |-> (dvalid == $past(rd_req)));

   a_r6_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && pipe && HAS_PIPE && !oe_n) |-> (dvalid == $past(rd_req, 2)));
endmodule

// File: rtl/dpr_core.sv
module dpr_core #(
   parameter int AW       = 10,
   parameter int DW       = 8,
   parameter bit HAS_PIPE = 1'b1
) (
   input  logic          l_clk,
   input  logic          l_rst_n,
   input  logic          l_ce_n,
   input  logic          l_ce,
   input  logic          l_wr_n,
   input  logic          l_oe_n,
   input  logic          l_pipe,
   input  logic [AW-1:0] l_addr,
   input  logic [DW-1:0] l_din,
   output logic [DW-1:0] l_dout,
   output logic          l_dvalid,
   input  logic          r_clk,
   input  logic          r_rst_n,
   input  logic          r_ce_n,
   input  logic          r_ce,
   input  logic          r_wr_n,
   input  logic          r_oe_n,
   input  logic          r_pipe,
   input  logic [AW-1:0] r_addr,
   input  logic [DW-1:0] r_din,
   output logic [DW-1:0] r_dout,
   output logic          r_dvalid
);
   generate
      if (AW < 1 || AW > 20) begin : g_bad_aw
         $error("dpr_core: AW must lie in 1..20");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dpr_core: DW must be at least 1");
      end
   endgenerate

   logic [DW-1:0] bl_at_l, bl_at_r, br_at_l, br_at_r;
   logic          l_bank_we, r_bank_we;
   logic [DW-1:0] l_bank_wd, r_bank_wd;
   logic          l_wr_req, r_wr_req;
   logic          r_block;

   // Left bank, written only by the left clock.
   dpr_bank #(.AW(AW), .DW(DW)) bank_l_i (
      .clk(l_clk), .we(l_bank_we), .wa(l_addr), .wd(l_bank_wd),
      .ra_l(l_addr), .ra_r(r_addr), .rd_l(bl_at_l), .rd_r(bl_at_r)
   );

   // Right bank, written only by the right clock.
   dpr_bank #(.AW(AW), .DW(DW)) bank_r_i (
      .clk(r_clk), .we(r_bank_we), .wa(r_addr), .wd(r_bank_wd),
      .ra_l(l_addr), .ra_r(r_addr), .rd_l(br_at_l), .rd_r(br_at_r)
   );

   // Same-address double write: the right port stands down (R8).
   assign r_block = l_wr_req && (l_addr == r_addr);

   dpr_port #(.AW(AW), .DW(DW), .HAS_PIPE(HAS_PIPE)) port_l_i (
      .clk(l_clk), .rst_n(l_rst_n), .ce_n(l_ce_n), .ce(l_ce), .wr_n(l_wr_n),
      .oe_n(l_oe_n), .pipe(l_pipe), .addr(l_addr), .din(l_din),
      .word_now(bl_at_l ^ br_at_l), .peer_word(br_at_l), .wr_block(1'b0),
      .wr_req(l_wr_req), .bank_we(l_bank_we), .bank_wd(l_bank_wd),
      .dout(l_dout), .dvalid(l_dvalid)
   );

   dpr_port #(.AW(AW), .DW(DW), .HAS_PIPE(HAS_PIPE)) port_r_i (
      .clk(r_clk), .rst_n(r_rst_n), .ce_n(r_ce_n), .ce(r_ce), .wr_n(r_wr_n),
      .oe_n(r_oe_n), .pipe(r_pipe), .addr(r_addr), .din(r_din),
      .word_now(bl_at_r ^ br_at_r), .peer_word(bl_at_r), .wr_block(r_block),
      .wr_req(r_wr_req), .bank_we(r_bank_we), .bank_wd(r_bank_wd),
      .dout(r_dout), .dvalid(r_dvalid)
   );

   a_r8_single_writer: assert property (@(posedge l_clk) disable iff (!l_rst_n || !r_rst_n)
      (l_bank_we && r_bank_we) |-> (l_addr != r_addr));

   a_r2_right_request_honoured: assert property (@(posedge r_clk) disable iff (!l_rst_n || !r_rst_n)
      (r_wr_req && !(l_wr_req && l_addr == r_addr)) |-> r_bank_we);
endmodule

// File: tb/dpr_core_tb.sv
module dpr_core_tb_top;
   localparam int  AW    = 10;
   localparam int  DW    = 8;
   localparam time CLK_P = 10ns;

   logic          l_clk = 1'b0, r_clk = 1'b0;
   logic          l_rst_n, r_rst_n;
   logic          l_ce_n, l_ce, l_wr_n, l_oe_n, l_pipe;
   logic          r_ce_n, r_ce, r_wr_n, r_oe_n, r_pipe;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_din, r_din, l_dout, r_dout;
   logic          l_dvalid, r_dvalid;

   int tests_run = 0;
   int tests_failed = 0;

   always #(CLK_P/2) l_clk = ~l_clk;
   always #(CLK_P/2) r_clk = ~r_clk;

   dpr_core #(.AW(AW), .DW(DW)) dut_i (
      .l_clk(l_clk), .l_rst_n(l_rst_n), .l_ce_n(l_ce_n), .l_ce(l_ce),
      .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe), .l_addr(l_addr),
      .l_din(l_din), .l_dout(l_dout), .l_dvalid(l_dvalid),
      .r_clk(r_clk), .r_rst_n(r_rst_n), .r_ce_n(r_ce_n), .r_ce(r_ce),
      .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe), .r_addr(r_addr),
      .r_din(r_din), .r_dout(r_dout), .r_dvalid(r_dvalid)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests_run++;
      if (got !== exp) begin
         tests_failed++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge l_clk);
      @(negedge l_clk);
   endtask

   task automatic drv_l(input logic ce_n, input logic ce, input logic wr_n,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      l_ce_n = ce_n; l_ce = ce; l_wr_n = wr_n; l_addr = a; l_din = d;
   endtask

   task automatic drv_r(input logic ce_n, input logic ce, input logic wr_n,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      r_ce_n = ce_n; r_ce = ce; r_wr_n = wr_n; r_addr = a; r_din = d;
   endtask

   task automatic idle_both();
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
   endtask

   task automatic t_reset();
      idle_both();
      l_oe_n = 1'b0; r_oe_n = 1'b0; l_pipe = 1'b0; r_pipe = 1'b0;
      l_rst_n = 1'b0; r_rst_n = 1'b0;
      tick(); tick();
      chk("R10 left dvalid in reset", l_dvalid, 0);
      chk("R10 right dvalid in reset", r_dvalid, 0);
      l_rst_n = 1'b1; r_rst_n = 1'b1;
      tick();
      chk("R10 left dout after reset", l_dout, 0);
      chk("R10 right dout after reset", r_dout, 0);
   endtask

   task automatic t_flow();
      l_pipe = 1'b0; r_pipe = 1'b0;
      drv_l(1'b0, 1'b1, 1'b0, 10'd5, 8'h3C); tick();
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b0, 1'b1, 1'b0, 10'd6, 8'h5A); tick();
      drv_r(1'b1, 1'b1, 1'b1, '0, '0);
      drv_l(1'b0, 1'b1, 1'b1, 10'd5, '0); tick();
      chk("R3 R5 left flow valid", l_dvalid, 1);
      chk("R2 R3 left flow data", l_dout, 8'h3C);
      drv_l(1'b0, 1'b1, 1'b1, 10'd6, '0); tick();
      chk("R2 left reads right's write", l_dout, 8'h5A);
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      drv_r(1'b0, 1'b1, 1'b1, 10'd5, '0); tick();
      chk("R2 right reads left's write", r_dout, 8'h3C);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0); tick();
      chk("R5 left flow gone after one edge", l_dvalid, 0);
      chk("R5 right flow gone after one edge", r_dvalid, 0);
   endtask

   task automatic t_pipe();
      r_pipe = 1'b1;
      drv_r(1'b0, 1'b1, 1'b0, 10'd9, 8'hA5); tick();
      drv_r(1'b0, 1'b1, 1'b1, 10'd9, '0); tick();
      chk("R6 pipe not yet valid", r_dvalid, 0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0); tick();
      chk("R6 pipe valid one edge later", r_dvalid, 1);
      chk("R6 pipe data", r_dout, 8'hA5);
      tick();
      chk("R6 pipe cleared", r_dvalid, 0);
   endtask

   task automatic t_modes();
      l_pipe = 1'b0; r_pipe = 1'b1;
      drv_l(1'b0, 1'b1, 1'b1, 10'd5, '0);
      drv_r(1'b0, 1'b1, 1'b1, 10'd5, '0); tick();
      idle_both();
      chk("R7 left flow shows first", l_dout, 8'h3C);
      chk("R7 right pipe holds back", r_dvalid, 0);
      tick();
      chk("R7 left flow done", l_dvalid, 0);
      chk("R7 right pipe now shows", r_dout, 8'h3C);
      tick();
      r_pipe = 1'b0;
   endtask

   task automatic t_desel();
      drv_l(1'b1, 1'b1, 1'b0, 10'd5, 8'hFF); tick();
      drv_l(1'b0, 1'b0, 1'b0, 10'd5, 8'hEE); tick();
      drv_l(1'b1, 1'b0, 1'b0, 10'd5, 8'hDD); tick();
      drv_l(1'b0, 1'b0, 1'b1, 10'd5, '0); tick();
      chk("R1 deselected read gives no drive", l_dvalid, 0);
      drv_l(1'b0, 1'b1, 1'b1, 10'd5, '0); tick();
      chk("R1 deselected writes ignored", l_dout, 8'h3C);
      drv_l(1'b1, 1'b1, 1'b1, '0, '0); tick();
   endtask

   task automatic t_oe();
      drv_l(1'b0, 1'b1, 1'b1, 10'd5, '0); tick();
      drv_l(1'b1, 1'b1, 1'b1, '0, '0);
      chk("R4 before oe change", l_dout, 8'h3C);
      #1 l_oe_n = 1'b1;
      #1;
      chk("R4 oe high drops flag", l_dvalid, 0);
      chk("R4 oe high zeroes data", l_dout, 0);
      l_oe_n = 1'b0;
      #1;
      chk("R4 oe low restores data", l_dout, 8'h3C);
      tick();
   endtask

   task automatic t_collide();
      drv_l(1'b0, 1'b1, 1'b0, 10'd20, 8'h11);
      drv_r(1'b0, 1'b1, 1'b0, 10'd20, 8'h22); tick();
      drv_l(1'b0, 1'b1, 1'b0, 10'd21, 8'h33);
      drv_r(1'b0, 1'b1, 1'b0, 10'd22, 8'h44); tick();
      drv_l(1'b0, 1'b1, 1'b1, 10'd20, '0);
      drv_r(1'b0, 1'b1, 1'b1, 10'd20, '0); tick();
      chk("R8 left wins (left view)", l_dout, 8'h11);
      chk("R8 left wins (right view)", r_dout, 8'h11);
      drv_l(1'b0, 1'b1, 1'b1, 10'd21, '0);
      drv_r(1'b0, 1'b1, 1'b1, 10'd22, '0); tick();
      chk("R8 distinct left write lands", l_dout, 8'h33);
      chk("R8 distinct right write lands", r_dout, 8'h44);
      idle_both(); tick();
   endtask

   task automatic t_rdw();
      drv_l(1'b0, 1'b1, 1'b0, 10'd30, 8'h40); tick();
      drv_l(1'b0, 1'b1, 1'b0, 10'd30, 8'h41);
      drv_r(1'b0, 1'b1, 1'b1, 10'd30, '0); tick();
      chk("R9 right read sees old word", r_dout, 8'h40);
      drv_l(1'b0, 1'b1, 1'b1, 10'd30, '0);
      drv_r(1'b0, 1'b1, 1'b0, 10'd30, 8'h42); tick();
      chk("R9 left read sees old word", l_dout, 8'h41);
      drv_l(1'b0, 1'b1, 1'b1, 10'd30, '0);
      drv_r(1'b1, 1'b1, 1'b1, '0, '0); tick();
      chk("R9 right write visible next edge", l_dout, 8'h42);
      idle_both(); tick();
   endtask

   initial begin
      repeat (100000) @(posedge l_clk);
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      t_reset();
      t_flow();
      t_pipe();
      t_modes();
      t_desel();
      t_oe();
      t_collide();
      t_rdw();
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule